// File: doc/BRIEF.md
# Quad Byte FIFO Bank with Fill-State Codes

This block holds four small byte queues for a serial bus controller: one each for the transmit and receive paths of its master side and of its slave side. Each queue holds at most two bytes by default. It has its own push port and its own pop port. The pop port works first-word-fall-through: the oldest byte is always visible on the pop data lane.

Each queue reports its fill state as a registered 2-bit code. The code tells an empty queue, a queue that took its first byte on the last clock, a queue that has held one byte for longer, and a full queue. The four codes are packed into one 16-bit control word that software reads. Writes to that word carry two self-clearing flush commands, one for each transmit queue.

A push into a full queue and a pop from an empty queue are dropped. Each such event sets a sticky per-queue error flag, which only reset clears.

Top module: `fbank_top`

## Requirements
- R1: After synchronous reset, every code reads 00 (empty), `reg_rdata` is 0x0000, and all bits of `ovf_err` and `unf_err` are 0.
- R2: A push into an empty queue gives code 01 in the cycle after the push edge, and the pushed byte appears on that queue's `pop_data` lane.
- R3: Code 01 changes to 10 one clock later when that queue sees no push, pop or flush.
- R4: With the default depth of 2, a push that makes the second stored byte gives code 11 (full).
- R5: Pops return bytes in push order. A pop from a full queue gives code 10, and a pop of the last byte gives code 00. A push and a pop in the same cycle on a one-byte queue give code 01, and on a full queue the code stays 11.
- R6: Channel c uses `push_en[c]`, `pop_en[c]`, `push_data[8c+7:8c]` and `pop_data[8c+7:8c]`, and its code sits at `reg_rdata[2c+1:2c]`. Channel 0 is slave transmit, 1 is slave receive, 2 is master transmit and 3 is master receive.
- R7: A cycle with `reg_wr`=1 and `reg_wdata[8]`=1 empties channel 0 at the next edge, and `reg_wdata[9]`=1 does the same for channel 2. The flush wins over a push or pop in that cycle: nothing is stored and no error flag is set. Other write bits, and the flush bits on the receive channels, have no effect.
- R8: `reg_rdata[15:8]` always reads zero. The flush bits are self-clearing, and bits 15:10 are reserved.
- R9: A push into a full queue without a pop in the same cycle is dropped. The queue contents and code are unchanged, and `ovf_err[c]` becomes 1 and stays 1 until reset.
- R10: A pop from an empty queue is dropped, and `unf_err[c]` becomes 1 and stays 1 until reset. A push in that same cycle is still accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| push_en | input | 4 | Per-channel push strobe |
| push_data | input | 32 | Per-channel push byte, 8 bits per lane |
| pop_en | input | 4 | Per-channel pop strobe |
| pop_data | output | 32 | Per-channel oldest byte, 8 bits per lane |
| reg_wr | input | 1 | Control word write strobe |
| reg_wdata | input | 16 | Control word write data (flush bits 8 and 9) |
| reg_rdata | output | 16 | Packed status codes, upper byte zero |
| ovf_err | output | 4 | Sticky push-into-full flags |
| unf_err | output | 4 | Sticky pop-from-empty flags |

## Verification
All codes, error flags and the head byte are updated by the edge that samples a push, pop or flush. They are therefore due one cycle after the stimulus, and code 01 turns to 10 on the edge after that. The bench changes its inputs on the falling clock edge and reads every result a few nanoseconds after the next rising edge. Each vector of its table holds the result expected at that single point, so no check straddles two edges. The flush-versus-push, push-into-full and pop-from-empty cases are each driven in one cycle and read in the cycle after it.

// File: rtl/fbank_pkg.sv
package fbank_pkg;
  localparam int CODE_W = 2;
  localparam int NCH    = 4;

  localparam int CH_STX = 0;
  localparam int CH_SRX = 1;
  localparam int CH_MTX = 2;
  localparam int CH_MRX = 3;

  localparam int FL_STX_BIT = 8;
  localparam int FL_MTX_BIT = 9;

  typedef enum logic [CODE_W-1:0] {
    FC_EMPTY = 2'b00,
    FC_FRESH = 2'b01,
    FC_HELD  = 2'b10,
    FC_FULL  = 2'b11
  } fcode_e;
endpackage

// File: rtl/fbank_fifo.sv
module fbank_fifo #(
  parameter int DW    = 8,
  parameter int DEPTH = 2
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         flush,
  input  logic                         push,
  input  logic [DW-1:0]                din,
  input  logic                         pop,
  output logic [DW-1:0]                dout,
  output logic [$clog2(DEPTH+1)-1:0]   cnt_nxt,
  output logic                         push_acc,
  output logic                         ovf_err,
  output logic                         unf_err
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH+1);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
  localparam logic [PW-1:0] LAST_PTR = PW'(DEPTH-1);

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] rd_ptr, wr_ptr;
  logic [CW-1:0] cnt;
  logic          pop_acc;

  function automatic logic [PW-1:0] adv(input logic [PW-1:0] p);
    return (p == LAST_PTR) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    pop_acc  = pop && !flush && (cnt != '0);
    push_acc = push && !flush && ((cnt != FULL_CNT) || pop_acc);
    cnt_nxt  = cnt;
    if (flush)
      cnt_nxt = '0;
    else if (push_acc && !pop_acc)
      cnt_nxt = cnt + 1'b1;
    else if (pop_acc && !push_acc)
      cnt_nxt = cnt - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (push_acc)
      mem[wr_ptr] <= din;
  end

  assign dout = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_ptr  <= '0;
      wr_ptr  <= '0;
      cnt     <= '0;
      ovf_err <= 1'b0;
      unf_err <= 1'b0;
    end else begin
      cnt <= cnt_nxt;
      if (flush) begin
        rd_ptr <= '0;
        wr_ptr <= '0;
      end else begin
        if (push_acc) wr_ptr <= adv(wr_ptr);
        if (pop_acc)  rd_ptr <= adv(rd_ptr);
        if (push && !push_acc) ovf_err <= 1'b1;
        if (pop && !pop_acc)   unf_err <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/fbank_code.sv
module fbank_code
  import fbank_pkg::*;
#(
  parameter int DEPTH = 2
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        flush,
  input  logic                        push_acc,
  input  logic [$clog2(DEPTH+1)-1:0]  cnt_nxt,
  output logic [CODE_W-1:0]           code
);
  localparam int CW = $clog2(DEPTH+1);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
  localparam logic [CW-1:0] ONE_CNT  = CW'(1);

  fcode_e code_q, code_d;

  always_comb begin
    if (flush || cnt_nxt == '0)
      code_d = FC_EMPTY;
    else if (cnt_nxt == FULL_CNT)
      code_d = FC_FULL;
    else if (push_acc && cnt_nxt == ONE_CNT)
      code_d = FC_FRESH;
    else
      code_d = FC_HELD;
  end

  always_ff @(posedge clk) begin
    if (rst) code_q <= FC_EMPTY;
    else     code_q <= code_d;
  end

  assign code = code_q;
endmodule

// File: rtl/fbank_top.sv
module fbank_top
  import fbank_pkg::*;
#(
  parameter int DW    = 8,
  parameter int DEPTH = 2,
  parameter int RW    = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NCH-1:0]    push_en,
  input  logic [NCH*DW-1:0] push_data,
  input  logic [NCH-1:0]    pop_en,
  output logic [NCH*DW-1:0] pop_data,
  input  logic              reg_wr,
  input  logic [RW-1:0]     reg_wdata,
  output logic [RW-1:0]     reg_rdata,
  output logic [NCH-1:0]    ovf_err,
  output logic [NCH-1:0]    unf_err
);
  localparam int CW    = $clog2(DEPTH+1);
  localparam int STAT_W = NCH*CODE_W;

  logic [NCH-1:0]        flush;
  logic [STAT_W-1:0]     codes;
  logic                  unused_wbits;

  assign unused_wbits = ^{reg_wdata[RW-1:FL_MTX_BIT+1], reg_wdata[STAT_W-1:0]};

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [CW-1:0] cnt_nxt;
    logic          push_acc;

    if (c == CH_STX) begin : g_fl
      assign flush[c] = reg_wr && reg_wdata[FL_STX_BIT];
    end else if (c == CH_MTX) begin : g_fl
      assign flush[c] = reg_wr && reg_wdata[FL_MTX_BIT];
    end else begin : g_nofl
      assign flush[c] = 1'b0;
    end

    fbank_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
      .clk      (clk),
      .rst      (rst),
      .flush    (flush[c]),
      .push     (push_en[c]),
      .din      (push_data[c*DW +: DW]),
      .pop      (pop_en[c]),
      .dout     (pop_data[c*DW +: DW]),
      .cnt_nxt  (cnt_nxt),
      .push_acc (push_acc),
      .ovf_err  (ovf_err[c]),
      .unf_err  (unf_err[c])
    );

    fbank_code #(.DEPTH(DEPTH)) u_code (
      .clk      (clk),
      .rst      (rst),
      .flush    (flush[c]),
      .push_acc (push_acc),
      .cnt_nxt  (cnt_nxt),
      .code     (codes[c*CODE_W +: CODE_W])
    );
  end

  assign reg_rdata = {{(RW-STAT_W){1'b0}}, codes};
endmodule

// File: rtl/fbank_chk.sv
module fbank_chk
  import fbank_pkg::*;
(
  input logic                  clk,
  input logic                  rst,
  input logic [NCH-1:0]        push_en,
  input logic [NCH-1:0]        pop_en,
  input logic                  reg_wr,
  input logic [1:0]            fl_bits,
  input logic [NCH*CODE_W-1:0] code_word,
  input logic [NCH-1:0]        ovf_err,
  input logic [NCH-1:0]        unf_err
);
  logic [NCH-1:0] fl;
  assign fl = {1'b0, reg_wr && fl_bits[1], 1'b0, reg_wr && fl_bits[0]};

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (code_word == '0 && ovf_err == '0 && unf_err == '0)); // R1

  for (genvar c = 0; c < NCH; c++) begin : g_c
    AST_FIRST_PUSH: assert property (@(posedge clk) disable iff (rst)
      (code_word[2*c +: 2] == 2'b00 && push_en[c] && !fl[c])
      |=> code_word[2*c +: 2] == 2'b01); // R2

    AST_SETTLE: assert property (@(posedge clk) disable iff (rst)
      (code_word[2*c +: 2] == 2'b01 && !push_en[c] && !pop_en[c] && !fl[c])
      |=> code_word[2*c +: 2] == 2'b10); // R3

    AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (rst)
      fl[c] |=> (code_word[2*c +: 2] == 2'b00 && $stable(ovf_err[c]))); // R7

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
      (code_word[2*c +: 2] == 2'b11 && push_en[c] && !pop_en[c] && !fl[c])
      |=> (code_word[2*c +: 2] == 2'b11 && ovf_err[c])); // R9

    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
      (code_word[2*c +: 2] == 2'b00 && pop_en[c] && !push_en[c] && !fl[c])
      |=> (code_word[2*c +: 2] == 2'b00 && unf_err[c])); // R10

    AST_STICKY_ERR: assert property (@(posedge clk) disable iff (rst)
      (ovf_err[c] || unf_err[c])
      |=> ($past(ovf_err[c]) ? ovf_err[c] : 1'b1) && ($past(unf_err[c]) ? unf_err[c] : 1'b1)); // R10
  end
endmodule

bind fbank_top fbank_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .push_en   (push_en),
  .pop_en    (pop_en),
  .reg_wr    (reg_wr),
  .fl_bits   (reg_wdata[9:8]),
  .code_word (reg_rdata[7:0]),
  .ovf_err   (ovf_err),
  .unf_err   (unf_err)
);

// File: tb/tb_fbank_top.sv
module tb_fbank_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  push_en = '0;
  logic [31:0] push_data = '0;
  logic [3:0]  pop_en = '0;
  logic [31:0] pop_data;
  logic        reg_wr = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic [3:0]  ovf_err, unf_err;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  fbank_top dut (
    .clk(clk), .rst(rst), .push_en(push_en), .push_data(push_data),
    .pop_en(pop_en), .pop_data(pop_data), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ovf_err(ovf_err), .unf_err(unf_err)
  );

  typedef struct packed {
    logic       psh;
    logic       pp;
    logic [7:0] din;
    logic [1:0] code;
    logic       chk;
    logic [7:0] head;
  } vec_t;

  // Channel 1 sequence; each row: stimulus, then code and head after the edge.
  localparam int NV = 14;
  localparam vec_t VEC [NV] = '{
    {1'b1, 1'b0, 8'hA5, 2'b01, 1'b1, 8'hA5},  // R2 first push
    {1'b0, 1'b0, 8'h00, 2'b10, 1'b1, 8'hA5},  // R3 settle
    {1'b1, 1'b0, 8'h3C, 2'b11, 1'b1, 8'hA5},  // R4 full
    {1'b0, 1'b0, 8'h00, 2'b11, 1'b1, 8'hA5},  // R4 hold
    {1'b1, 1'b0, 8'hFF, 2'b11, 1'b1, 8'hA5},  // R9 push into full dropped
    {1'b0, 1'b1, 8'h00, 2'b10, 1'b1, 8'h3C},  // R5 pop from full
    {1'b1, 1'b1, 8'h77, 2'b01, 1'b1, 8'h77},  // R5 push+pop at one
    {1'b0, 1'b1, 8'h00, 2'b00, 1'b0, 8'h00},  // R5 pop last
    {1'b0, 1'b1, 8'h00, 2'b00, 1'b0, 8'h00},  // R10 pop empty
    {1'b1, 1'b1, 8'h11, 2'b01, 1'b1, 8'h11},  // R10 push kept, pop dropped
    {1'b1, 1'b0, 8'h22, 2'b11, 1'b1, 8'h11},  // R4
    {1'b1, 1'b1, 8'h33, 2'b11, 1'b1, 8'h22},  // R5 push+pop at full
    {1'b0, 1'b1, 8'h00, 2'b10, 1'b1, 8'h33},  // R5 order
    {1'b0, 1'b1, 8'h00, 2'b00, 1'b0, 8'h00}   // R5 drained
  };

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic [3:0] psh, input logic [31:0] pd,
                     input logic [3:0] pp, input logic wr, input logic [15:0] wd);
    @(negedge clk);
    push_en = psh; push_data = pd; pop_en = pp; reg_wr = wr; reg_wdata = wd;
    @(posedge clk);
    #2;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected under 20000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst = 1'b1;
    cyc(4'h0, 32'h0, 4'h0, 1'b0, 16'h0);
    cyc(4'h0, 32'h0, 4'h0, 1'b0, 16'h0);
    rst = 1'b0;
    check(reg_rdata == 16'h0000, "R1 rdata", reg_rdata, 16'h0);
    check(ovf_err == 4'h0 && unf_err == 4'h0, "R1 err", {ovf_err, unf_err}, 0);

    for (int i = 0; i < NV; i++) begin
      cyc({2'b00, VEC[i].psh, 1'b0}, {16'h0, VEC[i].din, 8'h0},
          {2'b00, VEC[i].pp, 1'b0}, 1'b0, 16'h0);
      check(reg_rdata[3:2] == VEC[i].code, $sformatf("R2-5 code row %0d", i),
            reg_rdata[3:2], VEC[i].code);
      check({reg_rdata[15:4], reg_rdata[1:0]} == 14'h0, $sformatf("R6 other lanes row %0d", i),
            reg_rdata, {VEC[i].code, 2'b00});
      if (VEC[i].chk)
        check(pop_data[15:8] == VEC[i].head, $sformatf("R5 head row %0d", i),
              pop_data[15:8], VEC[i].head);
    end

    check(ovf_err == 4'b0010, "R9 ovf flag", ovf_err, 4'b0010);
    check(unf_err == 4'b0010, "R10 unf flag", unf_err, 4'b0010);
    cyc(4'h0, 32'h0, 4'h0, 1'b0, 16'h0);
    cyc(4'h0, 32'h0, 4'h0, 1'b0, 16'h0);
    check(ovf_err == 4'b0010 && unf_err == 4'b0010, "R10 sticky", {ovf_err, unf_err}, 8'h22);

    // R7: fill channel 0, then flush it while pushing into the full queue
    cyc(4'h1, 32'h0000_00C1, 4'h0, 1'b0, 16'h0);
    cyc(4'h1, 32'h0000_00C2, 4'h0, 1'b0, 16'h0);
    check(reg_rdata[1:0] == 2'b11, "R6 ch0 full", reg_rdata[1:0], 2'b11);
    check(pop_data[7:0] == 8'hC1, "R6 ch0 head", pop_data[7:0], 8'hC1);
    cyc(4'h1, 32'h0000_00C3, 4'h0, 1'b1, 16'h0100);
    check(reg_rdata[1:0] == 2'b00, "R7 flush ch0", reg_rdata[1:0], 2'b00);
    check(ovf_err[0] == 1'b0, "R7 no error on flush", ovf_err[0], 1'b0);
    check(reg_rdata[15:8] == 8'h00, "R8 upper byte", reg_rdata[15:8], 8'h00);
    cyc(4'h0, 32'h0, 4'h0, 1'b0, 16'h0);
    check(reg_rdata[1:0] == 2'b00, "R7 push lost to flush", reg_rdata[1:0], 2'b00);

    // R6/R7: channels 2 and 3, then writes without and with bit 9
    cyc(4'hC, 32'h5A00_0000 | 32'h0096_0000, 4'h0, 1'b0, 16'h0);
    check(reg_rdata[7:4] == 4'b0101, "R6 ch2/ch3 fresh", reg_rdata[7:4], 4'b0101);
    check(pop_data[31:16] == 16'h5A96, "R6 ch2/ch3 heads", pop_data[31:16], 16'h5A96);
    cyc(4'h0, 32'h0, 4'h0, 1'b1, 16'hFCFF);
    check(reg_rdata[7:4] == 4'b1010, "R7 other bits no flush", reg_rdata[7:4], 4'b1010);
    check(reg_rdata[15:8] == 8'h00, "R8 after write", reg_rdata[15:8], 8'h00);
    cyc(4'h0, 32'h0, 4'h0, 1'b1, 16'h0200);
    check(reg_rdata[7:4] == 4'b1000, "R7 flush ch2 only", reg_rdata[7:4], 4'b1000);
    check(pop_data[31:24] == 8'h5A, "R7 ch3 kept", pop_data[31:24], 8'h5A);
    check(ovf_err == 4'b0010 && unf_err == 4'b0010, "R7 flags unchanged",
          {ovf_err, unf_err}, 8'h22);

    // R1: reset clears codes and sticky flags
    rst = 1'b1;
    cyc(4'h0, 32'h0, 4'h0, 1'b0, 16'h0);
    rst = 1'b0;
    check(reg_rdata == 16'h0000, "R1 rdata after reset", reg_rdata, 16'h0);
    check(ovf_err == 4'h0 && unf_err == 4'h0, "R1 flags after reset",
          {ovf_err, unf_err}, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule